// File: doc/BRIEF.md
# Character Pattern Bank Mapper

The block turns a video pattern-table address into the page number of a character ROM, with a page size of 1 KB. Software loads eight bank values through the CPU register port. Each value is sixteen bits wide and is written as a low byte and a high byte. A mode field chooses how the 8 KB pattern space is split: one 8 KB window, two 4 KB halves, four 2 KB quarters, or eight 1 KB slots.

A control register adds two options. The first replaces every bank's high byte with a single shared 5-bit outer block. The second makes slots 2 and 3 reuse banks 0 and 1 in the 2 KB and 1 KB layouts. In the 4 KB layout, each half takes its bank from a latch. The latches are set by watching the video bus for particular tile fetches. The page output is purely combinational. Register writes and latch updates are clocked.

Top module: `chr_bank_map`

## Requirements
- R1: After reset every bank is 0, the mode is 0, block and mirror are off, and the low and high latches hold 0 and 4. The page therefore equals vid_addr[12:10].
- R2: A CPU write with cpu_addr[15:12]=9 loads the low byte of bank cpu_addr[2:0], and cpu_addr[15:12]=A loads that bank's high byte. cpu_addr[11:3] is ignored.
- R3: A write with cpu_addr[15:12]=D and cpu_addr[2:0]=0 sets the mode from cpu_wdata[4:3]. In mode 0 the page is bank0*8 + vid_addr[12:10].
- R4: In mode 2 the page is bank(2*vid_addr[12:11])*2 + vid_addr[10].
- R5: In mode 3 the page is bank(vid_addr[12:10]).
- R6: In mode 1 the page is bank(L)*4 + vid_addr[11:10]. L is the low latch when vid_addr[12]=0 and the high latch when vid_addr[12]=1.
- R7: A write with cpu_addr[15:12]=D and cpu_addr[2:0]=3 sets the options. When cpu_wdata[5]=0, block mode is on and each bank's upper byte becomes {3'b0, cpu_wdata[4:0]} in place of its high register.
- R8: When that write has cpu_wdata[7]=1 and the mode is 2 or 3, a reference to bank 2 uses bank 0 and a reference to bank 3 uses bank 1. In modes 0 and 1 the option has no effect.
- R9: A fetch with vid_rd=1 and (vid_addr AND 0x2FF8) equal to 0x0FD8 or 0x0FE8 loads the latch chosen by vid_addr[12] with {vid_addr[12], vid_addr[5], 0}. The possible values are 0 or 2 for the low latch and 4 or 6 for the high latch. No other fetch, and no address seen without vid_rd, changes a latch.
- R10: A fetch that updates a latch is itself mapped with the old latch value. The new value applies from the next fetch on.
- R11: With parameter LATCH_EN=0 the latches keep their reset values 0 and 4 whatever is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| vid_addr | input | 14 | Video bus address |
| vid_rd | input | 1 | Video pattern read strobe |
| chr_page | output | 19 | Character ROM 1 KB page number |

## Verification
A CPU write to a bank register and a latch-triggering pattern fetch can arrive in the same clock cycle. Both then take effect at the same edge. The bench drives a write of a new bank value together with a trigger fetch in one cycle. The trigger fetch must be mapped with the old latch and the old bank. The next fetch in that half must show the new latch pointing at the newly written bank. A second instance built with the latch feature disabled runs alongside on the same inputs. Its page is judged against the reset latch values.

// File: rtl/chr_bank_map.sv
module chr_bank_map #(
  parameter bit LATCH_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic [13:0] vid_addr,
  input  logic        vid_rd,
  output logic [18:0] chr_page
);
  localparam int NBANK = 8;
  localparam int IDX_W = $clog2(NBANK);

  logic [7:0]       lo_q [NBANK];
  logic [7:0]       hi_q [NBANK];
  logic [1:0]       chr_mode;
  logic             mirror_on, block_on;
  logic [4:0]       block_val;
  logic [2:0]       lat_lo, lat_hi;
  logic [IDX_W-1:0] idx;
  logic [15:0]      bank;
  logic             unused_bits;

  wire wr_lo   = cpu_we && cpu_addr[15:12] == 4'h9;
  wire wr_hi   = cpu_we && cpu_addr[15:12] == 4'hA;
  wire wr_mode = cpu_we && cpu_addr[15:12] == 4'hD && cpu_addr[2:0] == 3'd0;
  wire wr_ctl  = cpu_we && cpu_addr[15:12] == 4'hD && cpu_addr[2:0] == 3'd3;
  wire fetch_hit = vid_rd && !vid_addr[13] &&
                   (vid_addr[11:3] == 9'h1FB || vid_addr[11:3] == 9'h1FD);
  wire [2:0] lat_new = {vid_addr[12], vid_addr[5], 1'b0};

  assign unused_bits = ^{cpu_addr[11:3], vid_addr[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
      chr_mode  <= '0;
      mirror_on <= 1'b0;
      block_on  <= 1'b0;
      block_val <= '0;
    end else begin
      if (wr_lo) lo_q[cpu_addr[IDX_W-1:0]] <= cpu_wdata;
      if (wr_hi) hi_q[cpu_addr[IDX_W-1:0]] <= cpu_wdata;
      if (wr_mode) chr_mode <= cpu_wdata[4:3];
      if (wr_ctl) begin
        mirror_on <= cpu_wdata[7];
        block_on  <= !cpu_wdata[5];
        block_val <= cpu_wdata[4:0];
      end
    end
  end

  generate
    if (LATCH_EN) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lat_lo <= 3'd0;
          lat_hi <= 3'd4;
        end else if (fetch_hit) begin
          if (vid_addr[12]) lat_hi <= lat_new;
          else              lat_lo <= lat_new;
        end
      end
    end else begin : g_fixed
      assign lat_lo = 3'd0;
      assign lat_hi = 3'd4;
    end
  endgenerate

  always_comb begin
    case (chr_mode)
      2'd0:    idx = '0;
      2'd1:    idx = vid_addr[12] ? lat_hi : lat_lo;
      2'd2:    idx = {vid_addr[12:11], 1'b0};
      default: idx = vid_addr[12:10];
    endcase
    if (chr_mode[1] && mirror_on && idx[2:1] == 2'b01) idx[1] = 1'b0;
  end

  assign bank = block_on ? {3'b000, block_val, lo_q[idx]} : {hi_q[idx], lo_q[idx]};

  always_comb begin
    case (chr_mode)
      2'd0:    chr_page = {bank, vid_addr[12:10]};
      2'd1:    chr_page = {1'b0, bank, vid_addr[11:10]};
      2'd2:    chr_page = {2'b00, bank, vid_addr[10]};
      default: chr_page = {3'b000, bank};
    endcase
  end
endmodule

module chr_bank_map_chk #(
  parameter bit LATCH_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_we,
  input logic [15:0] cpu_addr,
  input logic [13:0] vid_addr,
  input logic        vid_rd,
  input logic [18:0] chr_page,
  input logic [1:0]  chr_mode,
  input logic [2:0]  lat_lo,
  input logic [2:0]  lat_hi
);
  wire hit = vid_rd && ((vid_addr & 14'h2FF8) == 14'h0FD8 || (vid_addr & 14'h2FF8) == 14'h0FE8);

  assert_mode0_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_mode == 2'd0 |-> chr_page[2:0] == vid_addr[12:10]);
  assert_mode1_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chr_mode == 2'd1 |-> chr_page[1:0] == vid_addr[11:10] && chr_page[18] == 1'b0);
  assert_mode2_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chr_mode == 2'd2 |-> chr_page[0] == vid_addr[10] && chr_page[18:17] == 2'b00);
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr[15:12] == 4'hD) |=> $stable(chr_mode));
  assert_latch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(lat_lo) && $stable(lat_hi));

  generate
    if (LATCH_EN) begin : g_on
      assert_latch_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !vid_addr[12] |=> lat_lo == {1'b0, $past(vid_addr[5]), 1'b0});
      assert_latch_load_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit && vid_addr[12] |=> lat_hi == {1'b1, $past(vid_addr[5]), 1'b0});
    end else begin : g_off
      assert_latch_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lat_lo == 3'd0 && lat_hi == 3'd4);
    end
  endgenerate
endmodule

bind chr_bank_map chr_bank_map_chk #(.LATCH_EN(LATCH_EN)) u_chk (.*);

// File: tb/sim_chr_bank_map.sv
`timescale 1ns/1ps
module sim_chr_bank_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] vid_addr = '0;
  logic        vid_rd = 1'b0;
  logic [18:0] page0, page1;

  always #2.5 clk = ~clk;

  chr_bank_map #(.LATCH_EN(1'b1)) u0 (.clk, .rst_n, .cpu_we, .cpu_addr, .cpu_wdata,
                                      .vid_addr, .vid_rd, .chr_page(page0));
  chr_bank_map #(.LATCH_EN(1'b0)) u1 (.clk, .rst_n, .cpu_we, .cpu_addr, .cpu_wdata,
                                      .vid_addr, .vid_rd, .chr_page(page1));

  typedef struct {
    logic [18:0] e0;
    logic [18:0] e1;
    string       tag;
  } item_t;
  item_t sb[$];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [8];
  logic [7:0] m_hi [8];
  logic [1:0] m_mode = 0;
  bit   m_mir = 0, m_blk = 0;
  logic [4:0] m_bval = 0;
  logic [2:0] m_l0 = 0, m_l1 = 4;

  function automatic logic [15:0] mbank(int i);
    return m_blk ? {3'b000, m_bval, m_lo[i]} : {m_hi[i], m_lo[i]};
  endfunction

  function automatic logic [18:0] mpage(logic [13:0] a, logic [2:0] l0, logic [2:0] l1);
    int s;
    logic [18:0] b;
    case (m_mode)
      2'd0: return 19'(mbank(0)) * 8 + 19'(a[12:10]);
      2'd1: begin
        b = 19'(mbank(a[12] ? int'(l1) : int'(l0)));
        return b * 4 + 19'(a[11:10]);
      end
      2'd2: begin
        s = int'(a[12:11]) * 2;
        if (m_mir && (s == 2 || s == 3)) s -= 2;
        return 19'(mbank(s)) * 2 + 19'(a[10]);
      end
      default: begin
        s = int'(a[12:10]);
        if (m_mir && (s == 2 || s == 3)) s -= 2;
        return 19'(mbank(s));
      end
    endcase
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    vid_rd = 1'b0; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_we = 1'b0;
    case (a[15:12])
      4'h9: m_lo[a[2:0]] = d;
      4'hA: m_hi[a[2:0]] = d;
      4'hD: if (a[2:0] == 3'd0) m_mode = d[4:3];
            else if (a[2:0] == 3'd3) begin m_mir = d[7]; m_blk = !d[5]; m_bval = d[4:0]; end
      default: ;
    endcase
  endtask

  function automatic void latch_model(logic [13:0] a, bit rd);
    int v;
    if (rd && ((a & 14'h2FF8) == 14'h0FD8 || (a & 14'h2FF8) == 14'h0FE8)) begin
      v = (int'(a) >> 4) & (((int'(a) >> 10) & 4) | 2);
      if (a[12]) m_l1 = 3'(v); else m_l0 = 3'(v);
    end
  endfunction

  task automatic fetch(logic [13:0] a, bit rd, string tag);
    item_t it;
    @(posedge clk); #1;
    vid_addr = a; vid_rd = rd;
    it.e0 = mpage(a, m_l0, m_l1);
    it.e1 = mpage(a, 3'd0, 3'd4);
    it.tag = tag;
    sb.push_back(it);
    latch_model(a, rd);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks += 2;
      if (page0 !== it.e0) begin
        fails++;
        $display("FAIL %s u0 addr=%h actual=%h expected=%h", it.tag, vid_addr, page0, it.e0);
      end
      if (page1 !== it.e1) begin
        fails++;
        $display("FAIL %s/R11 u1 addr=%h actual=%h expected=%h", it.tag, vid_addr, page1, it.e1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) fetch(14'(k * 1024 + 5), 1'b0, "R1 reset map");

    for (int i = 0; i < 8; i++) begin
      wr(16'h9000 | 16'(i), 8'(8'h11 * (i + 1)));
      wr(16'hA000 | 16'(i) | 16'h0FF8, 8'(i + 2));
    end
    wr(16'h9F5B, 8'hC3);
    fetch(14'h0000, 1'b0, "R2 mode0 after writes");
    fetch(14'h1C00, 1'b0, "R3 mode0 top slot");

    wr(16'hD000, 8'h18);
    for (int k = 0; k < 8; k++) fetch(14'(k * 1024 + 3), 1'b0, "R5 mode3");
    wr(16'hD000, 8'hF7);
    for (int k = 0; k < 8; k++) fetch(14'(k * 1024 + 7), 1'b0, "R4 mode2");

    wr(16'hD003, 8'hA0);
    for (int k = 0; k < 8; k++) fetch(14'(k * 1024), 1'b0, "R8 mirror mode2");
    wr(16'hD000, 8'h18);
    for (int k = 0; k < 8; k++) fetch(14'(k * 1024), 1'b0, "R8 mirror mode3");
    wr(16'hD000, 8'h00);
    fetch(14'h0C00, 1'b0, "R8 mirror no effect mode0");

    wr(16'hD003, 8'h15);
    wr(16'hD000, 8'h18);
    for (int k = 0; k < 8; k++) fetch(14'(k * 1024), 1'b0, "R7 block mode");
    wr(16'hD003, 8'h20);
    fetch(14'h1400, 1'b0, "R7 block off");

    wr(16'hD000, 8'h08);
    fetch(14'h0400, 1'b0, "R6 mode1 reset latches lo");
    fetch(14'h1800, 1'b0, "R6 mode1 reset latches hi");
    fetch(14'h0FE8, 1'b0, "R9 no strobe");
    fetch(14'h0000, 1'b0, "R9 no strobe no change");
    fetch(14'h2FE8, 1'b1, "R9 bit13 no trigger");
    fetch(14'h0000, 1'b1, "R9 bit13 no change");
    fetch(14'h0FEB, 1'b1, "R10 trigger uses old latch");
    fetch(14'h0800, 1'b1, "R9 low latch 2");
    fetch(14'h1FE8, 1'b1, "R10 trigger hi old");
    fetch(14'h1C00, 1'b1, "R9 high latch 6");
    fetch(14'h1FD8, 1'b1, "R9 high latch back");
    fetch(14'h1000, 1'b1, "R9 high latch 4");
    fetch(14'h0FD8, 1'b1, "R9 low latch back");
    fetch(14'h0400, 1'b1, "R9 low latch 0");
    wr(16'hD003, 8'hA0);
    fetch(14'h0FE8, 1'b1, "R8 mirror no effect mode1");
    fetch(14'h0C00, 1'b1, "R8 mirror mode1 latch 2");

    @(posedge clk); #1;
    vid_addr = 14'h1FE8; vid_rd = 1'b1;
    cpu_we = 1'b1; cpu_addr = 16'h9006; cpu_wdata = 8'h5A;
    begin
      item_t it;
      it.e0 = mpage(14'h1FE8, m_l0, m_l1);
      it.e1 = mpage(14'h1FE8, 3'd0, 3'd4);
      it.tag = "R10 same-cycle write and trigger";
      sb.push_back(it);
    end
    @(posedge clk); #1;
    cpu_we = 1'b0; vid_rd = 1'b0;
    m_lo[6] = 8'h5A;
    latch_model(14'h1FE8, 1'b1);
    fetch(14'h1400, 1'b0, "R10 new latch with new bank");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule